// File: doc/BRIEF.md
# Store Queue with Read-Miss Overtaking

This block sits between a write-through first-level data cache and the next level of memory. Stores leaving the cache are held in a small circular queue. They drain to memory one at a time, oldest first, each time the memory side accepts a request. A full queue holds off the cache with a not-ready signal.

A read miss does not wait for the queue to empty. Its line address is compared with every occupied slot. With no hit, the read goes to memory before any queued store. With a hit, the queue first drains up to and including the youngest matching slot, and the read follows. A read miss may carry a dirty victim. The victim is placed at the tail of the queue in the same cycle the miss is taken, so the refill read goes out first and the victim is written back later. The returned read data reaches the cache in the cycle memory delivers it, and the cache can then continue without waiting for any queued store.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the queue is empty: `mem_req_valid` is 0, `cs_rd_rsp_valid` is 0, and `cs_wr_ready` and `cs_rd_ready` are 1 while no read is offered.
- R2: Queued stores reach memory in the order they were accepted. Each store is issued as a request with `mem_req_write`=1 and leaves the queue on the cycle where `mem_req_valid` and `mem_req_ready` are both 1.
- R3: A read miss is compared against every occupied slot on the line address, which is address bits [AW-1:OFF_W] (OFF_W=4 by default). If no slot matches, the next memory request after the miss is accepted is the read (`mem_req_write`=0, full miss address), ahead of every queued store. Once offered, the read stays offered with the same address until memory accepts it.
- R4: If one or more slots match, every slot from the oldest up to and including the youngest matching one is written to memory in order before the read request is issued. Younger slots stay queued until after the read.
- R5: A miss accepted with `cs_rd_vic_valid`=1 puts the victim into the queue tail in the same cycle. The refill read is issued before the victim write, and the victim write follows any stores queued ahead of it. The victim line must differ from the miss line.
- R6: While the read is outstanding, `mem_rsp_valid` and `mem_rsp_data` pass straight through to `cs_rd_rsp_valid` and `cs_rd_rsp_data` in the same cycle. The following cycle the block accepts a new miss again.
- R7: With all DEPTH slots (4 by default) occupied, `cs_wr_ready` is 0, and a miss that carries a victim is held off (`cs_rd_ready`=0).
- R8: A store offered while not full is accepted even in the cycle the oldest slot drains, and neither entry is lost.
- R9: From the cycle a miss is accepted until its response is returned, and in any cycle a miss is being offered, `cs_wr_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_wr_valid | input | 1 | Cache offers a store |
| cs_wr_ready | output | 1 | Store accepted this cycle if valid |
| cs_wr_addr | input | AW | Store byte address |
| cs_wr_data | input | DW | Store data |
| cs_rd_valid | input | 1 | Cache offers a read miss |
| cs_rd_ready | output | 1 | Read miss accepted this cycle if valid |
| cs_rd_addr | input | AW | Read miss address |
| cs_rd_vic_valid | input | 1 | Miss carries a dirty victim |
| cs_rd_vic_addr | input | AW | Victim address |
| cs_rd_vic_data | input | DW | Victim data |
| cs_rd_rsp_valid | output | 1 | Read data returned to cache |
| cs_rd_rsp_data | output | DW | Returned read data |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Memory returns read data |
| mem_rsp_data | input | DW | Read data from memory |

## Verification
The bench stalls memory so that stores pile up, then sends a miss that matches no slot. A design that drained first, or compared only the head slot, would put a store before the read in the scoreboard. A miss that hits the middle slot shows whether the queue stops draining at the right point: stopping early returns stale data, and draining everything costs the bypass. A miss with a victim checks that the write-back does not overtake the refill. A store pushed in the very cycle a drain completes catches a queue that drops or duplicates entries when push and pop coincide. The full case checks that both the store path and a victim-carrying miss are held off.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_RDREQ = 2'd2,
    ST_RDWT  = 2'd3
  } wb_state_e;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [AW-1:0]            push_addr,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop,
  output logic [AW-1:0]            head_addr,
  output logic [DW-1:0]            head_data,
  output logic                     full,
  output logic                     empty,
  output logic [DEPTH-1:0]         slot_vld,
  output logic [DEPTH*AW-1:0]      slot_addr,
  output logic [$clog2(DEPTH)-1:0] head_ptr
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];

  // next-state for pointers and occupancy
  always_comb begin
    vld_d    = vld_q;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (pop) begin
      vld_d[rd_ptr_q] = 1'b0;
      rd_ptr_d        = rd_ptr_q + PTR_W'(1);
    end
    if (push) begin
      vld_d[wr_ptr_q] = 1'b1;
      wr_ptr_d        = wr_ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      vld_q    <= vld_d;
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  // payload storage, written only through its slot enable
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (wr_ptr_q == PTR_W'(s));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        addr_q[s] <= push_addr;
        data_q[s] <= push_data;
      end
    end
    assign slot_addr[s*AW +: AW] = addr_q[s];
  end

  assign slot_vld  = vld_q;
  assign head_ptr  = rd_ptr_q;
  assign head_addr = addr_q[rd_ptr_q];
  assign head_data = data_q[rd_ptr_q];
  assign full      = &vld_q;
  assign empty     = ~|vld_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop) && !vld_q[wr_ptr_q] || pop && (wr_ptr_q == rd_ptr_q) && !full); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> vld_q[rd_ptr_q]); // R2
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int OFF_W = 4
) (
  input  logic [DEPTH-1:0]           slot_vld,
  input  logic [DEPTH*AW-1:0]        slot_addr,
  input  logic [$clog2(DEPTH)-1:0]   head_ptr,
  input  logic [AW-1:0]              cmp_addr,
  output logic [$clog2(DEPTH+1)-1:0] need
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LINE_MASK = ~((AW'(1) << OFF_W) - AW'(1));

  logic [DEPTH-1:0] hit_slot;
  logic [DEPTH-1:0] hit_age;
  logic [PTR_W-1:0] age_idx [DEPTH];

  // one comparator per slot, on the line part of the address
  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign hit_slot[s] = slot_vld[s] &&
      (((slot_addr[s*AW +: AW] ^ cmp_addr) & LINE_MASK) == '0);
  end

  // rotate hits into age order, oldest first
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign age_idx[k] = head_ptr + PTR_W'(k);
    assign hit_age[k] = hit_slot[age_idx[k]];
  end

  // youngest hit decides how many slots must leave first
  always_comb begin
    need = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (hit_age[k]) need = CNT_W'(k + 1);
    end
  end
endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_rd_valid,
  input  logic                       cs_rd_vic_valid,
  input  logic [AW-1:0]              cs_rd_addr,
  input  logic                       full,
  input  logic [$clog2(DEPTH+1)-1:0] need,
  input  logic                       drain_pop,
  input  logic                       mem_req_ready,
  input  logic                       mem_rsp_valid,
  output wb_state_e                  state,
  output logic                       cs_rd_ready,
  output logic                       rd_accept,
  output logic [AW-1:0]              miss_addr
);
  localparam int CNT_W = $clog2(DEPTH+1);

  wb_state_e     st_q, st_d;
  logic [AW-1:0] miss_q;
  logic          clear_after;

  assign cs_rd_ready = (st_q == ST_IDLE) && (!cs_rd_vic_valid || !full);
  assign rd_accept   = cs_rd_valid && cs_rd_ready;
  // matching slots are gone once this cycle's drain is counted
  assign clear_after = (need == '0) || ((need == CNT_W'(1)) && drain_pop);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (rd_accept) st_d = clear_after ? ST_RDREQ : ST_DRAIN;
      ST_DRAIN: if (clear_after) st_d = ST_RDREQ;
      ST_RDREQ: if (mem_req_ready) st_d = ST_RDWT;
      ST_RDWT:  if (mem_rsp_valid) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (rd_accept) miss_q <= cs_rd_addr;
  end

  assign state     = st_q;
  assign miss_addr = miss_q;

  AST_RSP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RDWT) && mem_rsp_valid |=> cs_rd_ready || cs_rd_vic_valid); // R6
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
  import wbuf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int OFF_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_wr_valid,
  output logic          cs_wr_ready,
  input  logic [AW-1:0] cs_wr_addr,
  input  logic [DW-1:0] cs_wr_data,
  input  logic          cs_rd_valid,
  output logic          cs_rd_ready,
  input  logic [AW-1:0] cs_rd_addr,
  input  logic          cs_rd_vic_valid,
  input  logic [AW-1:0] cs_rd_vic_addr,
  input  logic [DW-1:0] cs_rd_vic_data,
  output logic          cs_rd_rsp_valid,
  output logic [DW-1:0] cs_rd_rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  wb_state_e          st;
  logic               full, empty, push, pop, rd_accept, drain_phase;
  logic [AW-1:0]      push_addr, head_addr, miss_addr, cmp_addr;
  logic [DW-1:0]      push_data, head_data;
  logic [DEPTH-1:0]   slot_vld;
  logic [DEPTH*AW-1:0] slot_addr;
  logic [PTR_W-1:0]   head_ptr;
  logic [CNT_W-1:0]   need;

  // stores wait whenever a miss is offered or in flight
  assign cs_wr_ready = !full && (st == ST_IDLE) && !cs_rd_valid;

  // victim takes the enqueue slot in the miss cycle
  always_comb begin
    push      = 1'b0;
    push_addr = cs_wr_addr;
    push_data = cs_wr_data;
    if (rd_accept && cs_rd_vic_valid) begin
      push      = 1'b1;
      push_addr = cs_rd_vic_addr;
      push_data = cs_rd_vic_data;
    end else if (cs_wr_valid && cs_wr_ready) begin
      push = 1'b1;
    end
  end

  assign drain_phase   = (st == ST_IDLE) || (st == ST_DRAIN);
  assign mem_req_valid = drain_phase ? !empty : (st == ST_RDREQ);
  assign mem_req_write = drain_phase;
  assign mem_req_addr  = drain_phase ? head_addr : miss_addr;
  assign mem_req_wdata = head_data;
  assign pop           = drain_phase && !empty && mem_req_ready;

  assign cs_rd_rsp_valid = (st == ST_RDWT) && mem_rsp_valid;
  assign cs_rd_rsp_data  = mem_rsp_data;

  assign cmp_addr = (st == ST_IDLE) ? cs_rd_addr : miss_addr;

  wbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (push_addr),
    .push_data (push_data),
    .pop       (pop),
    .head_addr (head_addr),
    .head_data (head_data),
    .full      (full),
    .empty     (empty),
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .head_ptr  (head_ptr)
  );

  wbuf_match #(.AW(AW), .DEPTH(DEPTH), .OFF_W(OFF_W)) u_match (
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .head_ptr  (head_ptr),
    .cmp_addr  (cmp_addr),
    .need      (need)
  );

  wbuf_ctrl #(.AW(AW), .DEPTH(DEPTH)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .cs_rd_valid     (cs_rd_valid),
    .cs_rd_vic_valid (cs_rd_vic_valid),
    .cs_rd_addr      (cs_rd_addr),
    .full            (full),
    .need            (need),
    .drain_pop       (pop),
    .mem_req_ready   (mem_req_ready),
    .mem_rsp_valid   (mem_rsp_valid),
    .state           (st),
    .cs_rd_ready     (cs_rd_ready),
    .rd_accept       (rd_accept),
    .miss_addr       (miss_addr)
  );

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> (need == '0)); // R4
  AST_RD_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write && !mem_req_ready) |=>
      (mem_req_valid && !mem_req_write && $stable(mem_req_addr))); // R3
  AST_MISS_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> !cs_wr_ready); // R9
endmodule

// File: tb/wbuf_bypass_bench.sv
`timescale 1ns/1ps
module wbuf_bypass_bench;
  localparam logic [31:0] RMAGIC = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_wr_valid, cs_wr_ready;
  logic [31:0] cs_wr_addr, cs_wr_data;
  logic        cs_rd_valid, cs_rd_ready;
  logic [31:0] cs_rd_addr;
  logic        cs_rd_vic_valid;
  logic [31:0] cs_rd_vic_addr, cs_rd_vic_data;
  logic        cs_rd_rsp_valid;
  logic [31:0] cs_rd_rsp_data;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int n_chk  = 0;
  int n_fail = 0;

  bit          exp_wr   [$];
  logic [31:0] exp_addr [$];
  logic [31:0] exp_data [$];
  string       exp_req  [$];

  always #10 clk = ~clk;

  wbuf_bypass u_wbuf_bypass (
    .clk(clk), .rst_n(rst_n),
    .cs_wr_valid(cs_wr_valid), .cs_wr_ready(cs_wr_ready),
    .cs_wr_addr(cs_wr_addr), .cs_wr_data(cs_wr_data),
    .cs_rd_valid(cs_rd_valid), .cs_rd_ready(cs_rd_ready),
    .cs_rd_addr(cs_rd_addr), .cs_rd_vic_valid(cs_rd_vic_valid),
    .cs_rd_vic_addr(cs_rd_vic_addr), .cs_rd_vic_data(cs_rd_vic_data),
    .cs_rd_rsp_valid(cs_rd_rsp_valid), .cs_rd_rsp_data(cs_rd_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_op(input bit wr, input logic [31:0] a, input logic [31:0] d,
                           input string req);
    exp_wr.push_back(wr);
    exp_addr.push_back(a);
    exp_data.push_back(d);
    exp_req.push_back(req);
  endtask

  // memory model: one-cycle read latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_write;
      mem_rsp_data  <= mem_req_addr ^ RMAGIC;
    end
  end

  // monitor: every memory handshake is popped and compared
  always @(negedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (exp_addr.size() == 0) begin
        check(1'b0, "R2", "unexpected request", mem_req_addr, 32'h0);
      end else begin
        bit          ew;
        logic [31:0] ea, ed;
        string       er;
        ew = exp_wr.pop_front();
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        er = exp_req.pop_front();
        check((mem_req_write == ew) && (mem_req_addr == ea) &&
              (!ew || (mem_req_wdata == ed)), er, "memory request order/addr",
              mem_req_addr, ea);
      end
    end
  end

  task automatic cs_write(input logic [31:0] a, input logic [31:0] d);
    cs_wr_valid = 1'b1;
    cs_wr_addr  = a;
    cs_wr_data  = d;
    @(negedge clk);
    while (!cs_wr_ready) @(negedge clk);
    @(posedge clk); #2;
    cs_wr_valid = 1'b0;
  endtask

  task automatic cs_read(input logic [31:0] a, input bit vic,
                         input logic [31:0] va, input logic [31:0] vd);
    cs_rd_valid     = 1'b1;
    cs_rd_addr      = a;
    cs_rd_vic_valid = vic;
    cs_rd_vic_addr  = va;
    cs_rd_vic_data  = vd;
    @(negedge clk);
    while (!cs_rd_ready) @(negedge clk);
    @(posedge clk); #2;
    cs_rd_valid     = 1'b0;
    cs_rd_vic_valid = 1'b0;
    @(negedge clk);
    check(!cs_wr_ready, "R9", "store port open during miss", 32'(cs_wr_ready), 32'h0);
    while (!cs_rd_rsp_valid) @(negedge clk);
    check(cs_rd_rsp_data == (a ^ RMAGIC), "R6", "read data", cs_rd_rsp_data, a ^ RMAGIC);
    @(posedge clk); #2;
    @(negedge clk);
    check(cs_rd_ready, "R6", "miss port ready after response", 32'(cs_rd_ready), 32'h1);
    @(posedge clk); #2;
  endtask

  task automatic wait_drained();
    while (exp_addr.size() != 0) @(negedge clk);
    @(negedge clk);
    check(!mem_req_valid, "R2", "queue empty after drain", 32'(mem_req_valid), 32'h0);
    @(posedge clk); #2;
  endtask

  task automatic release_mem_later();
    repeat (2) @(posedge clk);
    #2 mem_req_ready = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cs_wr_valid = 1'b0; cs_wr_addr = '0; cs_wr_data = '0;
    cs_rd_valid = 1'b0; cs_rd_addr = '0;
    cs_rd_vic_valid = 1'b0; cs_rd_vic_addr = '0; cs_rd_vic_data = '0;
    mem_req_ready = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!mem_req_valid, "R1", "mem_req_valid", 32'(mem_req_valid), 32'h0);
    check(!cs_rd_rsp_valid, "R1", "rsp_valid", 32'(cs_rd_rsp_valid), 32'h0);
    check(cs_wr_ready, "R1", "wr_ready", 32'(cs_wr_ready), 32'h1);
    check(cs_rd_ready, "R1", "rd_ready", 32'(cs_rd_ready), 32'h1);
    @(posedge clk); #2;

    // R7 and R2: fill while memory stalls, then drain in order
    for (int i = 1; i <= 4; i++) begin
      expect_op(1'b1, 32'(i) << 8, 32'hD000_0000 + 32'(i), "R2");
      cs_write(32'(i) << 8, 32'hD000_0000 + 32'(i));
    end
    @(negedge clk);
    check(!cs_wr_ready, "R7", "wr_ready when full", 32'(cs_wr_ready), 32'h0);
    @(posedge clk); #2;
    cs_rd_valid = 1'b1; cs_rd_addr = 32'h0000_F000;
    cs_rd_vic_valid = 1'b1; cs_rd_vic_addr = 32'h0000_E000;
    @(negedge clk);
    check(!cs_rd_ready, "R7", "victim miss held when full", 32'(cs_rd_ready), 32'h0);
    @(posedge clk); #2;
    cs_rd_valid = 1'b0; cs_rd_vic_valid = 1'b0;
    mem_req_ready = 1'b1;
    wait_drained();

    // R8: push in the same cycle the head drains
    mem_req_ready = 1'b0;
    for (int i = 5; i <= 7; i++) begin
      expect_op(1'b1, 32'(i) << 8, 32'hC000_0000 + 32'(i), "R8");
      cs_write(32'(i) << 8, 32'hC000_0000 + 32'(i));
    end
    expect_op(1'b1, 32'h0000_0800, 32'hC000_0008, "R8");
    mem_req_ready = 1'b1;
    cs_wr_valid = 1'b1; cs_wr_addr = 32'h0000_0800; cs_wr_data = 32'hC000_0008;
    @(negedge clk);
    check(cs_wr_ready && mem_req_valid && mem_req_write, "R8",
          "push accepted during drain", 32'(cs_wr_ready), 32'h1);
    @(posedge clk); #2;
    cs_wr_valid = 1'b0;
    wait_drained();

    // R3: miss with no match overtakes queued stores
    mem_req_ready = 1'b0;
    cs_write(32'h0000_1000, 32'hA000_0001);
    cs_write(32'h0000_2000, 32'hA000_0002);
    expect_op(1'b0, 32'h0000_3004, 32'h0, "R3");
    expect_op(1'b1, 32'h0000_1000, 32'hA000_0001, "R3");
    expect_op(1'b1, 32'h0000_2000, 32'hA000_0002, "R3");
    fork
      cs_read(32'h0000_3004, 1'b0, 32'h0, 32'h0);
      release_mem_later();
    join
    wait_drained();

    // R4: miss hits the middle slot on its line address
    mem_req_ready = 1'b0;
    cs_write(32'h0000_4000, 32'hB000_0001);
    cs_write(32'h0000_5008, 32'hB000_0002);
    cs_write(32'h0000_6000, 32'hB000_0003);
    expect_op(1'b1, 32'h0000_4000, 32'hB000_0001, "R4");
    expect_op(1'b1, 32'h0000_5008, 32'hB000_0002, "R4");
    expect_op(1'b0, 32'h0000_500C, 32'h0, "R4");
    expect_op(1'b1, 32'h0000_6000, 32'hB000_0003, "R4");
    fork
      cs_read(32'h0000_500C, 1'b0, 32'h0, 32'h0);
      release_mem_later();
    join
    wait_drained();

    // R5: victim written after the refill read
    mem_req_ready = 1'b0;
    cs_write(32'h0000_7000, 32'hE000_0001);
    expect_op(1'b0, 32'h0000_8000, 32'h0, "R5");
    expect_op(1'b1, 32'h0000_7000, 32'hE000_0001, "R5");
    expect_op(1'b1, 32'h0000_9000, 32'hE000_0009, "R5");
    fork
      cs_read(32'h0000_8000, 1'b1, 32'h0000_9000, 32'hE000_0009);
      release_mem_later();
    join
    wait_drained();

    // R5: victim into an empty queue with memory always ready
    mem_req_ready = 1'b1;
    expect_op(1'b0, 32'h0000_A000, 32'h0, "R5");
    expect_op(1'b1, 32'h0000_B000, 32'hE000_000B, "R5");
    cs_read(32'h0000_A000, 1'b1, 32'h0000_B000, 32'hE000_000B);
    wait_drained();

    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule